// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block is a first-in, first-out buffer between two clock domains. The write clock and the read clock run continuously. They may be unrelated or may be the same clock. A producer pushes a word on a write-clock edge when its two write enables agree and the buffer reports room. A consumer sees the oldest word in an output register. That register is filled without any request, so the first word written into an empty buffer falls through to the output by itself, and a ready flag then marks the output as valid.

A read is a pop of the word on display. It happens on a read-clock edge when the read enable and both output enables are active (low) and the output is valid. After the pop, the next word takes its place. Pointers cross the domain boundary as gray code through two-flop synchronizers. A half-full flag and an almost-full/almost-empty flag are derived from the memory occupancy. A parameter picks which clock domain computes them. The reset is asynchronous and clears every register in both domains.

Top module: `dc_fallthru_fifo`

## Requirements
- R1: A word is stored on a rising write-clock edge only when `wr_en_hi` is 1, `wr_en_lo_n` is 0 and `in_rdy` is 1. Any other combination stores nothing.
- R2: A pop happens on a rising read-clock edge only when `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_rdy` is 1. Without a pop, `rd_data` and `out_rdy` keep their values while the output holds a valid word.
- R3: If the output register is empty when a word is written, the word is loaded without any read request. `rd_data` shows it and `out_rdy` goes to 1 after the third rising read-clock edge following the write edge.
- R4: `in_rdy` is 0 during reset. It rises after the second rising write-clock edge following reset release.
- R5: The buffer holds 2^ADDR_W words in memory plus one in the output register. `in_rdy` falls after the write edge that fills the memory, as seen through the synchronized read pointer. While it is low, writes are ignored.
- R6: When a pop takes the last available word, `out_rdy` falls after that edge. While `out_rdy` is 0, `rd_data` keeps the last word that was popped.
- R7: `rd_data_hiz` equals `oe_a_n | oe_b_n`. While it is 1, no pop happens.
- R8: `half_full` is 1 when the memory occupancy, not counting the output register, is at least 2^(ADDR_W-1). It is 0 during reset.
- R9: `almost_edge` is 1 when the memory occupancy is at most ALMOST_E or at least 2^ADDR_W − ALMOST_F. It is 1 during reset.
- R10: With FLAG_SIDE set to the write side, both flags are registered on write edges. The occupancy used is the write pointer after the edge minus the synchronized read pointer. With FLAG_SIDE set to the read side, the flags are registered on read edges. The occupancy used is the synchronized write pointer minus the read pointer after the edge.
- R11: Words leave in the order they were written, with no loss and no duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | DATA_W | Word to store |
| wr_en_hi | input | 1 | Write enable, active high |
| wr_en_lo_n | input | 1 | Write enable, active low |
| in_rdy | output | 1 | Room available; write-clock registered |
| rd_en_n | input | 1 | Read enable, active low |
| oe_a_n | input | 1 | Output enable A, active low |
| oe_b_n | input | 1 | Output enable B, active low |
| rd_data | output | DATA_W | Output register contents |
| rd_data_hiz | output | 1 | Output would be undriven (either enable high) |
| out_rdy | output | 1 | `rd_data` holds a valid word; read-clock registered |
| half_full | output | 1 | Memory at least half occupied |
| almost_edge | output | 1 | Memory near empty or near full |

## Verification
The bench builds the block with ADDR_W = 4 and both almost offsets set to 3. This makes the memory 16 deep, so a full buffer, a blocked write, the half mark and both almost zones are reached within a few dozen cycles. It drives both ports from one clock, so the pointer synchronization latency is exact and every output can be predicted per cycle. A second instance uses the read-side flag variant, which covers both branches of the flag-domain parameter against the same stimulus.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   typedef enum logic {
      FLAG_WR_SIDE = 1'b0,
      FLAG_RD_SIDE = 1'b1
   } flag_side_e;

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("dcf_gray_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg_q <= '0;
      else         stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
   parameter int DW = 18,
   parameter int AW = 9
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int ENTRIES = 1 << AW;

   logic [DW-1:0] mem [ENTRIES];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
   parameter int AW = 9
) (
   input  logic        clk,
   input  logic        arst_n,
   input  logic        en_hi,
   input  logic        en_lo_n,
   input  logic [AW:0] rgray_s,
   output logic        we,
   output logic [AW-1:0] waddr,
   output logic [AW:0] wgray,
   output logic        in_rdy,
   output logic [AW:0] lvl_next
);

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [PW-1:0] wbin_q, wbin_d, rbin_s, wgray_q;
   logic          live_q, rdy_q;

   always_comb begin
      for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
   end

   assign we       = en_hi & ~en_lo_n & rdy_q;
   assign wbin_d   = wbin_q + PW'(we);
   assign lvl_next = wbin_d - rbin_s;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         wbin_q  <= '0;
         wgray_q <= '0;
         live_q  <= 1'b0;
         rdy_q   <= 1'b0;
      end else begin
         wbin_q  <= wbin_d;
         wgray_q <= wbin_d ^ (wbin_d >> 1);
         live_q  <= 1'b1;
         rdy_q   <= live_q && (lvl_next != PW'(DEPTH));
      end
   end

   assign waddr  = wbin_q[AW-1:0];
   assign wgray  = wgray_q;
   assign in_rdy = rdy_q;

   // R5
   wr_blocked_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !$past(rdy_q) |-> wbin_q == $past(wbin_q));

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (wbin_q - rbin_s) <= PW'(DEPTH));

   // R3
   wgray_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
      $onehot0(wgray_q ^ $past(wgray_q)));

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
   parameter int DW = 18,
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          rd_en_n,
   input  logic          oe_a_n,
   input  logic          oe_b_n,
   input  logic [AW:0]   wgray_s,
   input  logic [DW-1:0] mem_q,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] dout,
   output logic          out_rdy,
   output logic [AW:0]   lvl_next
);

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [PW-1:0] rbin_q, rbin_d, wbin_s, rgray_q;
   logic [DW-1:0] dout_q;
   logic          rdy_q, rd_go, avail, load;

   always_comb begin
      for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
   end

   assign rd_go    = ~rd_en_n & ~oe_a_n & ~oe_b_n & rdy_q;
   assign avail    = (wbin_s != rbin_q);
   assign load     = avail & (~rdy_q | rd_go);
   assign rbin_d   = rbin_q + PW'(load);
   assign lvl_next = wbin_s - rbin_d;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         rbin_q  <= '0;
         rgray_q <= '0;
         rdy_q   <= 1'b0;
         dout_q  <= '0;
      end else begin
         rbin_q  <= rbin_d;
         rgray_q <= rbin_d ^ (rbin_d >> 1);
         rdy_q   <= load | (rdy_q & ~rd_go);
         if (load) dout_q <= mem_q;
      end
   end

   assign raddr   = rbin_q[AW-1:0];
   assign rgray   = rgray_q;
   assign dout    = dout_q;
   assign out_rdy = rdy_q;

   // R6
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !rdy_q |-> dout_q == $past(dout_q));

   // R2
   no_underflow_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (wbin_s - rbin_q) <= PW'(DEPTH));

   // R2
   read_gate_chk: assert property (@(posedge clk) disable iff (!arst_n)
      ($past(rdy_q) && ($past(rd_en_n) || $past(oe_a_n) || $past(oe_b_n)))
      |-> (rdy_q && dout_q == $past(dout_q)));

endmodule

// File: rtl/dcf_level_flags.sv
module dcf_level_flags #(
   parameter int AW = 9,
   parameter int AE = 64,
   parameter int AF = 64
) (
   input  logic        clk,
   input  logic        arst_n,
   input  logic [AW:0] lvl,
   output logic        half,
   output logic        almost
);

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;
   localparam int HALF  = DEPTH / 2;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         half   <= 1'b0;
         almost <= 1'b1;
      end else begin
         half   <= (lvl >= PW'(HALF));
         almost <= (lvl <= PW'(AE)) || (lvl >= PW'(DEPTH - AF));
      end
   end

   // R8
   half_vs_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (half && $past(lvl) <= PW'(AE)) |-> 1'b0);

endmodule

// File: rtl/dc_fallthru_fifo.sv
module dc_fallthru_fifo #(
   parameter int                 DATA_W    = 18,
   parameter int                 ADDR_W    = 9,
   parameter int                 ALMOST_E  = 64,
   parameter int                 ALMOST_F  = 64,
   parameter dcf_pkg::flag_side_e FLAG_SIDE = dcf_pkg::FLAG_WR_SIDE
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              arst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en_hi,
   input  logic              wr_en_lo_n,
   output logic              in_rdy,
   input  logic              rd_en_n,
   input  logic              oe_a_n,
   input  logic              oe_b_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_data_hiz,
   output logic              out_rdy,
   output logic              half_full,
   output logic              almost_edge
);

   localparam int PW          = ADDR_W + 1;
   localparam int DEPTH       = 1 << ADDR_W;
   localparam int SYNC_STAGES = 2;

   if (ADDR_W < 2) begin : g_bad_depth
      $error("dc_fallthru_fifo: ADDR_W must be at least 2");
   end
   if (ALMOST_E < 0 || ALMOST_E >= DEPTH / 2) begin : g_bad_ae
      $error("dc_fallthru_fifo: ALMOST_E out of range");
   end
   if (ALMOST_F < 1 || ALMOST_F >= DEPTH / 2) begin : g_bad_af
      $error("dc_fallthru_fifo: ALMOST_F out of range");
   end

   logic              we;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s, lvl_w, lvl_r, lvl_sel;
   logic [DATA_W-1:0] mem_q;
   logic              flag_clk;

   dcf_wr_ctl #(.AW(ADDR_W)) u_wr (
      .clk(wr_clk), .arst_n(arst_n), .en_hi(wr_en_hi), .en_lo_n(wr_en_lo_n),
      .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
      .in_rdy(in_rdy), .lvl_next(lvl_w)
   );

   dcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
      .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(mem_q)
   );

   dcf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .arst_n(arst_n), .d(wgray), .q(wgray_s)
   );

   dcf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .arst_n(arst_n), .d(rgray), .q(rgray_s)
   );

   dcf_rd_ctl #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
      .clk(rd_clk), .arst_n(arst_n), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n),
      .oe_b_n(oe_b_n), .wgray_s(wgray_s), .mem_q(mem_q), .raddr(raddr),
      .rgray(rgray), .dout(rd_data), .out_rdy(out_rdy), .lvl_next(lvl_r)
   );

   assign flag_clk = (FLAG_SIDE == dcf_pkg::FLAG_WR_SIDE) ? wr_clk : rd_clk;
   assign lvl_sel  = (FLAG_SIDE == dcf_pkg::FLAG_WR_SIDE) ? lvl_w  : lvl_r;

   dcf_level_flags #(.AW(ADDR_W), .AE(ALMOST_E), .AF(ALMOST_F)) u_flags (
      .clk(flag_clk), .arst_n(arst_n), .lvl(lvl_sel),
      .half(half_full), .almost(almost_edge)
   );

   assign rd_data_hiz = oe_a_n | oe_b_n;

   // R7
   hiz_blocks_pop_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
      ($past(rd_data_hiz) && $past(out_rdy)) |-> out_rdy);

endmodule

// File: tb/test_dc_fallthru_fifo.sv
module test_dc_fallthru_fifo;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 18;
   localparam int AW         = 4;
   localparam int DEPTH      = 1 << AW;
   localparam int AE         = 3;
   localparam int AF         = 3;
   localparam int WD_CYCLES  = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic we_hi = 1'b0, we_lo_n = 1'b1, ren_n = 1'b1, oea_n = 1'b0, oeb_n = 1'b0;
   logic [DW-1:0] wdata = '0;

   logic ir, orr, hiz, hf, al;
   logic [DW-1:0] dout;
   logic ir2, orr2, hiz2, hf2, al2;
   logic [DW-1:0] dout2;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dc_fallthru_fifo #(.DATA_W(DW), .ADDR_W(AW), .ALMOST_E(AE), .ALMOST_F(AF),
                      .FLAG_SIDE(dcf_pkg::FLAG_WR_SIDE)) i_dc_fallthru_fifo (
      .wr_clk(clk), .rd_clk(clk), .arst_n(rst_n), .wr_data(wdata),
      .wr_en_hi(we_hi), .wr_en_lo_n(we_lo_n), .in_rdy(ir), .rd_en_n(ren_n),
      .oe_a_n(oea_n), .oe_b_n(oeb_n), .rd_data(dout), .rd_data_hiz(hiz),
      .out_rdy(orr), .half_full(hf), .almost_edge(al)
   );

   dc_fallthru_fifo #(.DATA_W(DW), .ADDR_W(AW), .ALMOST_E(AE), .ALMOST_F(AF),
                      .FLAG_SIDE(dcf_pkg::FLAG_RD_SIDE)) i_dc_fallthru_fifo_rd (
      .wr_clk(clk), .rd_clk(clk), .arst_n(rst_n), .wr_data(wdata),
      .wr_en_hi(we_hi), .wr_en_lo_n(we_lo_n), .in_rdy(ir2), .rd_en_n(ren_n),
      .oe_a_n(oea_n), .oe_b_n(oeb_n), .rd_data(dout2), .rd_data_hiz(hiz2),
      .out_rdy(orr2), .half_full(hf2), .almost_edge(al2)
   );

   // behavioural reference: counts, histories, queue of written words
   int            wp_h[$];
   int            rp_h[$];
   logic [DW-1:0] dlog[$];
   logic          m_ir, m_live, m_or, m_hf_w, m_al_w, m_hf_r, m_al_r;
   logic [DW-1:0] m_dout;

   task automatic model_reset();
      wp_h = {0};
      rp_h = {0};
      dlog.delete();
      m_ir = 0; m_live = 0; m_or = 0; m_dout = '0;
      m_hf_w = 0; m_al_w = 1; m_hf_r = 0; m_al_r = 1;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         int n, wc, rc, ws, rs, nw, nr, wl, rl;
         bit wfire, rfire, load;
         n  = wp_h.size();
         wc = wp_h[n-1];
         rc = rp_h[n-1];
         ws = (n >= 3) ? wp_h[n-3] : 0;   // pointer seen across the boundary
         rs = (n >= 3) ? rp_h[n-3] : 0;
         wfire = we_hi && !we_lo_n && m_ir;
         if (wfire) dlog.push_back(wdata);
         nw = wc + (wfire ? 1 : 0);
         wl = nw - rs;
         rfire = !ren_n && !oea_n && !oeb_n && m_or;
         load  = (ws != rc) && (!m_or || rfire);
         if (load) m_dout = dlog[rc];
         nr = rc + (load ? 1 : 0);
         rl = ws - nr;
         m_or   = load || (m_or && !rfire);
         m_ir   = m_live && (wl < DEPTH);
         m_live = 1;
         m_hf_w = (wl >= DEPTH / 2);
         m_al_w = (wl <= AE) || (wl >= DEPTH - AF);
         m_hf_r = (rl >= DEPTH / 2);
         m_al_r = (rl <= AE) || (rl >= DEPTH - AF);
         wp_h.push_back(nw);
         rp_h.push_back(nr);
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R4 R5 in_rdy",              32'(ir),   32'(m_ir));
      chk("R3 R6 out_rdy",             32'(orr),  32'(m_or));
      chk("R1 R2 R11 rd_data",         32'(dout), 32'(m_dout));
      chk("R7 rd_data_hiz",            32'(hiz),  32'(oea_n | oeb_n));
      chk("R8 half_full",              32'(hf),   32'(m_hf_w));
      chk("R9 almost_edge",            32'(al),   32'(m_al_w));
      chk("R10 half_full read side",   32'(hf2),  32'(m_hf_r));
      chk("R10 almost_edge read side", 32'(al2),  32'(m_al_r));
   endtask

   task automatic step(input logic h, input logic l, input logic r,
                       input logic a, input logic b, input logic [DW-1:0] d);
      @(negedge clk);
      check_all();
      we_hi = h; we_lo_n = l; ren_n = r; oea_n = a; oeb_n = b; wdata = d;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog all requirements: actual=timeout expected=completion");
         summary();
      end
   end

   initial begin
      // reset state: in_rdy/out_rdy/half low, almost high (R4 R8 R9)
      repeat (5) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
      rst_n = 1'b1;
      // R4: in_rdy rises on the second edge
      repeat (3) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
      // R5 R3 R7: fill with reads inhibited by an output enable
      for (int i = 0; i < 22; i++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, DW'(18'h100 + i));
      // R1: wrong enable pairs while draining
      for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, DW'(18'h200 + i));
      for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, DW'(18'h280 + i));
      // streaming
      for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, DW'(18'h300 + i));
      // R6: drain to empty
      repeat (30) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      // R3: single word into empty with no read request
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 18'h2A5A5);
      repeat (6) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0);
      // mixed patterns
      for (int i = 0; i < 800; i++) begin
         step(($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
              ($urandom % 6) == 0, ($urandom % 6) == 0, DW'($urandom));
      end
      repeat (30) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
      done = 1'b1;
      summary();
   end

endmodule